// File: doc/BRIEF.md
# Flash Fetch Buffer Arbiter

This block connects two CPU read ports, one for instruction fetches and one for data (literal) reads, to a single flash read port whose latency is set by a wait-state input. Flash delivers a 64-bit line per read. Each CPU port has its own line buffer holding the last line fetched for it. The instruction side also has a second buffer that is filled with the next sequential line while flash would otherwise sit idle. A request whose line is already held in one of that port's buffers is answered in the same cycle, with no flash traffic at all.

A request that hits nothing stalls its port and starts a flash read once flash is free. When both ports miss at once, the data port goes first. A started read always runs to completion, so a data miss can take the place of a pending prefetch only before that prefetch starts. A synchronous flush input drops every buffered line.

Each port uses a single-phase valid/ready handshake. The requester holds valid and the address until ready is seen, and the 32-bit response is valid in the same cycle as ready.

Top module: `flash_line_arbiter`

## Requirements
- R1: After reset all buffers are empty, flashRdEn is low, and with no request pending both ready outputs are low.
- R2: A request whose line address (address bits 31:3) matches a valid buffer of its port is answered in the same cycle. Address bit 2 selects the returned word: 0 gives line bits 31:0 and 1 gives line bits 63:32.
- R3: A miss seen while flash is idle raises flashRdEn in the next cycle and holds it for exactly waitStates+1 cycles, with flashLineAddr equal to the requested line address. Ready rises in the cycle after the last read cycle, which is waitStates+2 cycles after the miss was first seen.
- R4: If both ports miss in a cycle where flash is idle, the data line is read first and the instruction read starts only after it completes.
- R5: A completed read stores its line in the buffer of the port that requested it. Later requests to that line start no flash read.
- R6: When flash is idle, neither port misses, and the instruction buffer is valid, a read of the next line (instruction tag + 1) starts unless the prefetch buffer already holds that line.
- R7: An instruction request that misses the current line but hits the prefetch buffer is served in the same cycle. That line then becomes the current line, and the prefetch buffer is emptied.
- R8: A flash read, once started, is never aborted or redirected. A miss arriving during a prefetch waits for the prefetch to finish.
- R9: The cycle after flush is high, all buffers are invalid. No read starts in a flush cycle. A read already running completes, but a line completing in the flush cycle is not stored.
- R10: Each stall output equals its port's valid AND NOT ready.
- R11: waitStates is sampled when a read starts. Changing it during a read does not change that read's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous invalidate of all line buffers |
| waitStates | input | 3 | Extra flash read cycles, 0 to 7 |
| iReqValid | input | 1 | Instruction request valid |
| iReqAddr | input | 32 | Instruction byte address |
| iReqReady | output | 1 | Instruction request served this cycle |
| iRspData | output | 32 | Instruction word, valid with iReqReady |
| iStall | output | 1 | Instruction port waiting |
| dReqValid | input | 1 | Data request valid |
| dReqAddr | input | 32 | Data byte address |
| dReqReady | output | 1 | Data request served this cycle |
| dRspData | output | 32 | Data word, valid with dReqReady |
| dStall | output | 1 | Data port waiting |
| flashRdEn | output | 1 | Flash read in progress |
| flashLineAddr | output | 29 | Line address being read |
| flashRdata | input | 64 | Line returned by flash, captured on the last read cycle |

## Verification
A wrong tag or valid bit shows at the ports within one cycle of the next request to that line. Either a request is answered with no flash read, or a read starts on a line that should have hit. A wrong word select or a misfiled capture shows up as a wrong response word on the first hit after the fill. A counter or arbitration fault changes the length of flashRdEn, its address, or which port becomes ready first, all within a single read window. The bench follows every cycle with a behavioural model, so each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_DATA  = 2'd1,
    OWN_INSTR = 2'd2,
    OWN_PREF  = 2'd3
  } owner_e;

  typedef struct packed {
    logic capData;
    logic capInstr;
    logic capPref;
    logic promote;
    logic flush;
  } arbStrobe_t;

endpackage

// File: rtl/flash_line_buf.sv
module flash_line_buf #(
  parameter int TAG_W  = 29,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              load,
  input  logic              drop,
  input  logic [TAG_W-1:0]  loadTag,
  input  logic [LINE_W-1:0] loadLine,
  input  logic [TAG_W-1:0]  lookTag,
  output logic              hit,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] line
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= 1'b0;
      tag   <= '0;
      line  <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      tag   <= loadTag;
      line  <= loadLine;
    end else if (drop) begin
      valid <= 1'b0;
    end
  end

  always_comb hit = valid && (tag == lookTag);

endmodule

// File: rtl/flash_arb_datapath.sv
module flash_arb_datapath
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  arbStrobe_t                    strobe,
  input  logic                          iReqValid,
  input  logic [ADDR_W-1:0]             iReqAddr,
  input  logic                          dReqValid,
  input  logic [ADDR_W-1:0]             dReqAddr,
  input  logic [ADDR_W-$clog2(LINE_W/8)-1:0] fillTag,
  input  logic [LINE_W-1:0]             fillLine,
  output logic                          iCurHit,
  output logic                          iPfHit,
  output logic                          dHit,
  output logic                          pfNeed,
  output logic [ADDR_W-$clog2(LINE_W/8)-1:0] nextTag,
  output logic                          iReqReady,
  output logic [DATA_W-1:0]             iRspData,
  output logic                          dReqReady,
  output logic [DATA_W-1:0]             dRspData
);

  localparam int OFF_W  = $clog2(LINE_W/8);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int SEL_W  = OFF_W - BYTE_W;
  localparam int TAG_W  = ADDR_W - OFF_W;

  logic [TAG_W-1:0]  iTag, dTag;
  logic [SEL_W-1:0]  iSel, dSel;
  logic              iCurValid, iPfValid, dValid;
  logic [TAG_W-1:0]  iCurTag, iPfTag, dCurTag;
  logic [LINE_W-1:0] iCurLine, iPfLine, dCurLine, iLine;
  logic              curLoad;
  logic [TAG_W-1:0]  curLoadTag;
  logic [LINE_W-1:0] curLoadLine;

  always_comb begin
    iTag = iReqAddr[ADDR_W-1:OFF_W];
    dTag = dReqAddr[ADDR_W-1:OFF_W];
    iSel = iReqAddr[OFF_W-1:BYTE_W];
    dSel = dReqAddr[OFF_W-1:BYTE_W];
    // Fill from flash takes precedence over promotion of the prefetch line.
    curLoad     = strobe.capInstr | strobe.promote;
    curLoadTag  = strobe.capInstr ? fillTag  : iPfTag;
    curLoadLine = strobe.capInstr ? fillLine : iPfLine;
  end

  flash_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_iCur (
    .clk(clk), .rstN(rstN), .clear(strobe.flush), .load(curLoad), .drop(1'b0),
    .loadTag(curLoadTag), .loadLine(curLoadLine), .lookTag(iTag),
    .hit(iCurHit), .valid(iCurValid), .tag(iCurTag), .line(iCurLine)
  );

  flash_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_iPf (
    .clk(clk), .rstN(rstN), .clear(strobe.flush), .load(strobe.capPref),
    .drop(strobe.promote),
    .loadTag(fillTag), .loadLine(fillLine), .lookTag(iTag),
    .hit(iPfHit), .valid(iPfValid), .tag(iPfTag), .line(iPfLine)
  );

  flash_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_dCur (
    .clk(clk), .rstN(rstN), .clear(strobe.flush), .load(strobe.capData),
    .drop(1'b0),
    .loadTag(fillTag), .loadLine(fillLine), .lookTag(dTag),
    .hit(dHit), .valid(dValid), .tag(dCurTag), .line(dCurLine)
  );

  always_comb begin
    nextTag   = iCurTag + 1'b1;
    pfNeed    = iCurValid && !(iPfValid && (iPfTag == nextTag));
    iReqReady = iReqValid && (iCurHit || iPfHit);
    dReqReady = dReqValid && dHit;
    iLine     = iCurHit ? iCurLine : iPfLine;
    iRspData  = iLine[iSel*DATA_W +: DATA_W];
    dRspData  = dCurLine[dSel*DATA_W +: DATA_W];
  end

  // R9: a flush leaves every buffer empty in the next cycle
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (!iCurValid && !iPfValid && !dValid));

  // R5: a data fill lands in the data buffer with the read's line address
  a_r5_data_fill: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capData && !strobe.flush) |=> (dValid && dCurTag == $past(fillTag)));

  // R7: a promoted prefetch line leaves the prefetch buffer empty
  a_r7_promote_empties: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.promote && !strobe.capPref && !strobe.flush) |=> !iPfValid);

endmodule

// File: rtl/flash_arb_ctrl.sv
module flash_arb_ctrl
  import flash_arb_pkg::*;
#(
  parameter int TAG_W = 29,
  parameter int WS_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [WS_W-1:0]  waitStates,
  input  logic             iReqValid,
  input  logic             dReqValid,
  input  logic             iCurHit,
  input  logic             iPfHit,
  input  logic             dHit,
  input  logic             pfNeed,
  input  logic [TAG_W-1:0] iTag,
  input  logic [TAG_W-1:0] dTag,
  input  logic [TAG_W-1:0] nextTag,
  output arbStrobe_t       strobe,
  output logic             flashRdEn,
  output logic [TAG_W-1:0] flashLineAddr
);

  logic             busy;
  logic [WS_W-1:0]  cnt;
  owner_e           owner;
  logic [TAG_W-1:0] lineAddr;
  logic             iMiss, dMiss, done, start;
  owner_e           pick;
  logic [TAG_W-1:0] pickAddr;

  always_comb begin
    iMiss = iReqValid && !iCurHit && !iPfHit;
    dMiss = dReqValid && !dHit;
    done  = busy && (cnt == '0);
    start = !busy && !flush && (dMiss || iMiss || pfNeed);
    // Fixed priority: data, then instruction, then prefetch.
    if (dMiss) begin
      pick = OWN_DATA;  pickAddr = dTag;
    end else if (iMiss) begin
      pick = OWN_INSTR; pickAddr = iTag;
    end else begin
      pick = OWN_PREF;  pickAddr = nextTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      owner    <= OWN_NONE;
      lineAddr <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= waitStates;
      owner    <= pick;
      lineAddr <= pickAddr;
    end else if (done) begin
      busy     <= 1'b0;
      owner    <= OWN_NONE;
    end else if (busy) begin
      cnt      <= cnt - 1'b1;
    end
  end

  always_comb begin
    strobe.capData  = done && (owner == OWN_DATA);
    strobe.capInstr = done && (owner == OWN_INSTR);
    strobe.capPref  = done && (owner == OWN_PREF);
    strobe.promote  = iReqValid && !iCurHit && iPfHit;
    strobe.flush    = flush;
    flashRdEn       = busy;
    flashLineAddr   = lineAddr;
  end

  // R3: the flash address holds for the whole read
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy && $stable(flashLineAddr)));

  // R11: the latched wait count steps down once per cycle
  a_r11_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (cnt == $past(cnt) - 1'b1));

  // R4: a data miss at a free slot wins the flash
  a_r4_data_first: assert property (@(posedge clk) disable iff (!rstN)
    (start && dMiss) |=> (owner == OWN_DATA));

  // R8: a running read keeps its owner
  a_r8_no_preempt: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (owner == $past(owner)));

  // R9: no read starts in a flush cycle
  a_r9_flush_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && flush) |=> !busy);

endmodule

// File: rtl/flash_line_arbiter.sv
module flash_line_arbiter
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64,
  parameter int DATA_W = 32,
  parameter int WS_W   = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 flush,
  input  logic [WS_W-1:0]                      waitStates,
  input  logic                                 iReqValid,
  input  logic [ADDR_W-1:0]                    iReqAddr,
  output logic                                 iReqReady,
  output logic [DATA_W-1:0]                    iRspData,
  output logic                                 iStall,
  input  logic                                 dReqValid,
  input  logic [ADDR_W-1:0]                    dReqAddr,
  output logic                                 dReqReady,
  output logic [DATA_W-1:0]                    dRspData,
  output logic                                 dStall,
  output logic                                 flashRdEn,
  output logic [ADDR_W-$clog2(LINE_W/8)-1:0]   flashLineAddr,
  input  logic [LINE_W-1:0]                    flashRdata
);

  localparam int OFF_W = $clog2(LINE_W/8);
  localparam int TAG_W = ADDR_W - OFF_W;

  arbStrobe_t       strobe;
  logic             iCurHit, iPfHit, dHit, pfNeed;
  logic [TAG_W-1:0] nextTag;

  flash_arb_ctrl #(.TAG_W(TAG_W), .WS_W(WS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .waitStates(waitStates),
    .iReqValid(iReqValid), .dReqValid(dReqValid),
    .iCurHit(iCurHit), .iPfHit(iPfHit), .dHit(dHit), .pfNeed(pfNeed),
    .iTag(iReqAddr[ADDR_W-1:OFF_W]), .dTag(dReqAddr[ADDR_W-1:OFF_W]),
    .nextTag(nextTag), .strobe(strobe),
    .flashRdEn(flashRdEn), .flashLineAddr(flashLineAddr)
  );

  flash_arb_datapath #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .iReqValid(iReqValid), .iReqAddr(iReqAddr),
    .dReqValid(dReqValid), .dReqAddr(dReqAddr),
    .fillTag(flashLineAddr), .fillLine(flashRdata),
    .iCurHit(iCurHit), .iPfHit(iPfHit), .dHit(dHit), .pfNeed(pfNeed),
    .nextTag(nextTag),
    .iReqReady(iReqReady), .iRspData(iRspData),
    .dReqReady(dReqReady), .dRspData(dRspData)
  );

  always_comb begin
    iStall = iReqValid && !iReqReady;
    dStall = dReqValid && !dReqReady;
  end

endmodule

// File: tb/flash_line_arbiter_tb.sv
module flash_line_arbiter_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [2:0]  waitStates = 3'd0;
  logic        iReqValid = 1'b0, dReqValid = 1'b0;
  logic [31:0] iReqAddr = '0, dReqAddr = '0;
  logic        iReqReady, dReqReady, iStall, dStall, flashRdEn;
  logic [31:0] iRspData, dRspData;
  logic [28:0] flashLineAddr;
  logic [63:0] flashRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // flash contents: a fixed function of the line address
  assign flashRdata = {flashLineAddr, 3'b110, flashLineAddr, 3'b001};

  flash_line_arbiter u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .waitStates(waitStates),
    .iReqValid(iReqValid), .iReqAddr(iReqAddr), .iReqReady(iReqReady),
    .iRspData(iRspData), .iStall(iStall),
    .dReqValid(dReqValid), .dReqAddr(dReqAddr), .dReqReady(dReqReady),
    .dRspData(dRspData), .dStall(dStall),
    .flashRdEn(flashRdEn), .flashLineAddr(flashLineAddr), .flashRdata(flashRdata)
  );

  // reference model state
  bit        mBusy;
  int        mCnt;
  int        mOwner;   // 0 none, 1 data, 2 instr, 3 prefetch
  bit [28:0] mAddr;
  bit        mIV, mPV, mDV;
  bit [28:0] mITag, mPTag, mDTag;
  bit        lastIRdy, lastDRdy;

  function automatic logic [31:0] wordOf(input logic [31:0] a);
    return a[2] ? {a[31:3], 3'b110} : {a[31:3], 3'b001};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mBusy = 0; mCnt = 0; mOwner = 0; mAddr = '0;
    mIV = 0; mPV = 0; mDV = 0; mITag = '0; mPTag = '0; mDTag = '0;
  endtask

  // one clock: compare, advance model, cross the edge
  task automatic step();
    bit hitCur, hitPf, hitD, iMiss, dMiss, pfNeed, done;
    bit expI, expD;
    bit nBusy, nIV, nPV, nDV;
    int nCnt, nOwner;
    bit [28:0] nAddr, nITag, nPTag, nDTag;
    #1;
    hitCur = iReqValid && mIV && (mITag == iReqAddr[31:3]);
    hitPf  = iReqValid && mPV && (mPTag == iReqAddr[31:3]);
    hitD   = dReqValid && mDV && (mDTag == dReqAddr[31:3]);
    expI = hitCur || hitPf;
    expD = hitD;
    check(iReqReady == expI, "R2 iReady", 64'(iReqReady), 64'(expI));
    check(dReqReady == expD, "R2 dReady", 64'(dReqReady), 64'(expD));
    if (expI) check(iRspData == wordOf(iReqAddr), "R2 iData", 64'(iRspData), 64'(wordOf(iReqAddr)));
    if (expD) check(dRspData == wordOf(dReqAddr), "R2 dData", 64'(dRspData), 64'(wordOf(dReqAddr)));
    check(iStall == (iReqValid && !expI), "R10 iStall", 64'(iStall), 64'(iReqValid && !expI));
    check(dStall == (dReqValid && !expD), "R10 dStall", 64'(dStall), 64'(dReqValid && !expD));
    check(flashRdEn == mBusy, "R3 flashRdEn", 64'(flashRdEn), 64'(mBusy));
    if (mBusy) check(flashLineAddr == mAddr, "R3 flashLineAddr", 64'(flashLineAddr), 64'(mAddr));
    lastIRdy = expI; lastDRdy = expD;

    iMiss  = iReqValid && !expI;
    dMiss  = dReqValid && !expD;
    pfNeed = mIV && !(mPV && mPTag == mITag + 29'd1);
    done   = mBusy && mCnt == 0;
    nBusy = mBusy; nCnt = mCnt; nOwner = mOwner; nAddr = mAddr;
    nIV = mIV; nITag = mITag; nPV = mPV; nPTag = mPTag; nDV = mDV; nDTag = mDTag;
    if (iReqValid && !hitCur && hitPf) begin  // R7 promotion
      nIV = 1; nITag = mPTag; nPV = 0;
    end
    if (mBusy) begin
      if (done) begin
        nBusy = 0; nOwner = 0;
        if (mOwner == 1) begin nDV = 1; nDTag = mAddr; end
        if (mOwner == 2) begin nIV = 1; nITag = mAddr; end
        if (mOwner == 3) begin nPV = 1; nPTag = mAddr; end
      end else nCnt = mCnt - 1;
    end else if (!flush && (dMiss || iMiss || pfNeed)) begin
      nBusy = 1; nCnt = waitStates;
      if (dMiss) begin nOwner = 1; nAddr = dReqAddr[31:3]; end
      else if (iMiss) begin nOwner = 2; nAddr = iReqAddr[31:3]; end
      else begin nOwner = 3; nAddr = mITag + 29'd1; end
    end
    if (flush) begin nIV = 0; nPV = 0; nDV = 0; end
    @(posedge clk);
    mBusy = nBusy; mCnt = nCnt; mOwner = nOwner; mAddr = nAddr;
    mIV = nIV; mITag = nITag; mPV = nPV; mPTag = nPTag; mDV = nDV; mDTag = nDTag;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // hold requests until served; report steps to each service
  task automatic doReq(input bit iv, input logic [31:0] ia, input bit dv,
                       input logic [31:0] da, output int iSteps, output int dSteps);
    iReqValid = iv; iReqAddr = ia; dReqValid = dv; dReqAddr = da;
    iSteps = 0; dSteps = 0;
    for (int n = 1; n <= 60 && (iReqValid || dReqValid); n++) begin
      step();
      if (iReqValid && lastIRdy) begin iReqValid = 0; iSteps = n; end
      if (dReqValid && lastDRdy) begin dReqValid = 0; dSteps = n; end
    end
    check(!iReqValid && !dReqValid, "R3 service", 64'(iReqValid | dReqValid), 64'd0);
    iReqValid = 0; dReqValid = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int is, ds;
    int fr;
    logic [31:0] ia, da;
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(flashRdEn == 0, "R1 flashRdEn", 64'(flashRdEn), 0);
    check(iReqReady == 0 && dReqReady == 0, "R1 ready", 64'({iReqReady, dReqReady}), 0);
    rstN = 1'b1;
    idle(3);

    // R3: instruction miss, 3 wait states -> served on step ws+3
    waitStates = 3'd3;
    doReq(1, 32'h100, 0, 0, is, ds);
    check(is == 6, "R3 instr miss latency", 64'(is), 64'd6);
    // R2: same line, upper word, immediate
    doReq(1, 32'h104, 0, 0, is, ds);
    check(is == 1, "R2 hit same cycle", 64'(is), 64'd1);
    // R6: prefetch of 0x108 happens while idle
    idle(7);
    // R7: hit in prefetch buffer
    doReq(1, 32'h108, 0, 0, is, ds);
    check(is == 1, "R7 prefetch hit", 64'(is), 64'd1);
    idle(7);
    doReq(1, 32'h110, 0, 0, is, ds);
    check(is == 1, "R7 chained prefetch", 64'(is), 64'd1);

    // R3 R5: data miss with 0 wait states, then reuse
    waitStates = 3'd0;
    doReq(0, 0, 1, 32'h2000, is, ds);
    check(ds == 3, "R3 data miss latency", 64'(ds), 64'd3);
    doReq(0, 0, 1, 32'h2004, is, ds);
    check(ds == 1, "R5 data reuse", 64'(ds), 64'd1);

    // R4: simultaneous misses, data first
    waitStates = 3'd2;
    doReq(1, 32'h4000, 1, 32'h3000, is, ds);
    check(ds < is, "R4 data before instr", 64'(ds), 64'(is));

    // R8: data miss arriving after a prefetch has started waits for it
    waitStates = 3'd5;
    doReq(1, 32'h800, 0, 0, is, ds);
    step();            // prefetch starts here
    doReq(0, 0, 1, 32'h5000, is, ds);
    check(ds == 13, "R8 waits for prefetch", 64'(ds), 64'd13);

    // R11: waitStates change during a read
    waitStates = 3'd5;
    iReqValid = 1; iReqAddr = 32'h9000;
    step();
    waitStates = 3'd0;
    is = 1;
    while (!lastIRdy && is < 40) begin step(); is++; end
    check(is == 8, "R11 latched wait states", 64'(is), 64'd8);
    iReqValid = 0;
    idle(3);

    // R9: flush drops buffered lines
    flush = 1'b1;
    step();
    doReq(0, 0, 1, 32'h5000, is, ds);
    check(ds == 3, "R9 data refetch after flush", 64'(ds), 64'd3);

    // random traffic with reference comparison every cycle
    ia = 32'h1000; da = 32'h8000;
    for (int r = 0; r < 400; r++) begin
      if (!iReqValid && $urandom_range(0, 3) != 0) begin
        if ($urandom_range(0, 4) == 0) ia = 32'h1000 + 4 * $urandom_range(0, 63);
        else ia = ia + 4;
        iReqValid = 1; iReqAddr = ia;
      end
      if (!dReqValid && $urandom_range(0, 2) == 0) begin
        da = 32'h8000 + 4 * $urandom_range(0, 15);
        dReqValid = 1; dReqAddr = da;
      end
      if ($urandom_range(0, 15) == 0) waitStates = 3'($urandom_range(0, 7));
      fr = $urandom_range(0, 49);
      flush = (fr == 0);
      step();
      if (iReqValid && lastIRdy) iReqValid = 0;
      if (dReqValid && lastDRdy) dReqValid = 0;
    end
    iReqValid = 0; dReqValid = 0;
    idle(10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule